// File: doc/BRIEF.md
# Seed-Lock Test Pattern Checker

This block checks a test pattern on the receive side of a serial link. The link carries fixed-width words that an upstream stage has already aligned to block boundaries. The checker holds a copy of the transmit-side pattern generator. That copy produces four segments of equal length in a fixed order: segment A, A inverted, segment B, B inverted. After the last segment the cycle starts again. The transmitter runs through this cycle without any knowledge of the receiver.

To find its place in the stream, the checker starts in a search state. In that state its expected word is pinned to the opening word of segment A. It does not advance while it searches. When an incoming word is exactly equal to that opening word, the local generator is released and runs in step with the stream.

From then on, every valid block is compared with the word the generator predicts. Each block that differs is reported with a one-cycle pulse and added to a saturating counter. The count goes up by one for each errored block, whatever the number of wrong bits in it. A long unbroken run of errored blocks means that sync has been lost, and the checker goes back to searching. An external restart does the same and also clears the count.

Top module: `seed_lock_checker`

## Requirements
- R1: After reset and after any cycle with `restart_i` high, `locked_o` is 0, `err_o` is 0 and `err_count_o` is 0 from the next clock edge. `restart_i` takes priority over a block presented in the same cycle.
- R2: While unlocked, a valid word that is not exactly `SEED_A` (this includes every single-bit variant and the bitwise inverse) leaves `locked_o` at 0. It raises no `err_o` and does not change `err_count_o`.
- R3: While unlocked, a valid word equal to `SEED_A` sets `locked_o` to 1 at the next clock edge.
- R4: The generator emits 4 segments of `SEG_WORDS` words each. Word 0 of a segment is its base: `SEED_A` for segments 0 and 1, `SEED_B` for segments 2 and 3. Word j+1 is derived from word j (before any inversion) by x^=x<<13; x^=x>>7; x^=x<<17. Segments 1 and 3 are emitted bitwise inverted. After segment 3 the sequence returns to segment 0, word 0.
- R5: The first valid word after lock is compared against word 1 of segment 0.
- R6: Cycles with `blk_valid_i` low neither advance the generator nor affect lock, `err_o` or the count.
- R7: A locked valid block that differs from the expected word in one or more bits gives a single `err_o` pulse in the next cycle and increments `err_count_o` by exactly 1. Errored blocks still advance the generator.
- R8: `LOSS_LIMIT` (16) consecutive errored blocks clear `locked_o`, and the last of them is still counted. A correct block resets the run.
- R9: `err_count_o` saturates at 2^`CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous return to search, clears count |
| blk_valid_i | input | 1 | A word is present on `blk_data_i` |
| blk_data_i | input | W | Block-aligned payload word |
| locked_o | output | 1 | Pattern sync held |
| err_o | output | 1 | Pulse: previous valid block was errored |
| err_count_o | output | CNT_W | Saturating errored-block count |

## Verification
The assertions assume that `rst_n`, `restart_i` and `blk_valid_i` always carry known values. They also assume that a valid word stays on `blk_data_i` for the whole cycle in which `blk_valid_i` is sampled. The bench drives every input on the falling edge and only with defined values, so no sample lands near a changing input. The bench runs a small configuration (4-word segments, 6-bit count). This lets it sweep every single-bit corruption of the lock word, several full pattern periods with idle cycles mixed in, both sides of the loss threshold, and counter saturation.

// File: rtl/seed_lock_checker.sv
module seed_lock_checker #(
  parameter int W          = 64,
  parameter int SEG_WORDS  = 8,
  parameter int LOSS_LIMIT = 16,
  parameter int CNT_W      = 16,
  parameter logic [W-1:0] SEED_A = 64'h0123_4567_89AB_CDEF,
  parameter logic [W-1:0] SEED_B = 64'h5A5A_3C3C_0F0F_9696
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             blk_valid_i,
  input  logic [W-1:0]     blk_data_i,
  output logic             locked_o,
  output logic             err_o,
  output logic [CNT_W-1:0] err_count_o
);

  localparam int IDX_W  = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1;
  localparam int MISS_W = (LOSS_LIMIT > 1) ? $clog2(LOSS_LIMIT) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(SEG_WORDS - 1);
  localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(LOSS_LIMIT - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  function automatic logic [W-1:0] xs(input logic [W-1:0] x);
    logic [W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  logic             locked_q;
  logic             err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MISS_W-1:0] miss_q;
  logic [W-1:0]     gen_q;
  logic [1:0]       seg_q;
  logic [IDX_W-1:0] idx_q;

  logic             seg_end;
  logic [1:0]       seg_nx;
  logic [IDX_W-1:0] idx_nx;
  logic [W-1:0]     gen_nx;
  logic [W-1:0]     expect_w;
  logic             mismatch;

  assign seg_end  = (idx_q == LAST_IDX);
  assign seg_nx   = seg_end ? seg_q + 2'd1 : seg_q;
  assign idx_nx   = seg_end ? '0 : idx_q + 1'b1;
  assign gen_nx   = seg_end ? (seg_nx[1] ? SEED_B : SEED_A) : xs(gen_q);
  assign expect_w = locked_q ? (gen_q ^ {W{seg_q[0]}}) : SEED_A;
  assign mismatch = (blk_data_i != expect_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      miss_q   <= '0;
      gen_q    <= SEED_A;
      seg_q    <= 2'd0;
      idx_q    <= '0;
    end else if (restart_i) begin
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      miss_q   <= '0;
      gen_q    <= SEED_A;
      seg_q    <= 2'd0;
      idx_q    <= '0;
    end else begin
      err_q <= 1'b0;
      if (blk_valid_i) begin
        if (!locked_q) begin
          if (!mismatch) begin
            locked_q <= 1'b1;
            gen_q    <= xs(SEED_A);
            seg_q    <= 2'd0;
            idx_q    <= IDX_W'(1);
            miss_q   <= '0;
          end
        end else begin
          gen_q <= gen_nx;
          seg_q <= seg_nx;
          idx_q <= idx_nx;
          if (mismatch) begin
            err_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (miss_q == LAST_MISS) begin
              locked_q <= 1'b0;
              miss_q   <= '0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end else begin
            miss_q <= '0;
          end
        end
      end
    end
  end

  assign locked_o    = locked_q;
  assign err_o       = err_q;
  assign err_count_o = cnt_q;

  p_restart_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!locked_o && !err_o && err_count_o == '0));

  p_no_err_searching_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !restart_i) |=> (!err_o && $stable(err_count_o)));

  p_lock_on_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !restart_i && blk_valid_i && blk_data_i == SEED_A) |=> locked_o);

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !blk_valid_i) |=> ($stable(locked_o) && !err_o && $stable(err_count_o)));

  p_err_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(locked_o) && (err_count_o != $past(err_count_o) || err_count_o == CNT_MAX)));

  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> (err_count_o == $past(err_count_o) || err_count_o == $past(err_count_o) + 1'b1));

  p_unlock_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> ($past(restart_i) || err_o));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count_o == CNT_MAX && !restart_i) |=> err_count_o == CNT_MAX);

endmodule

// File: tb/test_seed_lock_checker.sv
module test_seed_lock_checker;
  localparam int W = 64;
  localparam int SEG = 4;
  localparam int PERIOD = 4 * SEG;
  localparam int LOSS = 16;
  localparam int CW = 6;
  localparam logic [W-1:0] SA = 64'h0123_4567_89AB_CDEF;
  localparam logic [W-1:0] SB = 64'h5A5A_3C3C_0F0F_9696;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_i = 1'b0;
  logic blk_valid_i = 1'b0;
  logic [W-1:0] blk_data_i = '0;
  logic locked_o, err_o;
  logic [CW-1:0] err_count_o;

  int n_tests = 0;
  int n_fail = 0;
  logic m_lock = 1'b0;
  int m_pos = 0;
  int m_cnt = 0;
  int m_miss = 0;
  logic m_err = 1'b0;

  always #5 clk = ~clk;

  seed_lock_checker #(.W(W), .SEG_WORDS(SEG), .LOSS_LIMIT(LOSS), .CNT_W(CW),
                      .SEED_A(SA), .SEED_B(SB)) i_seed_lock_checker (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .blk_valid_i(blk_valid_i),
    .blk_data_i(blk_data_i), .locked_o(locked_o), .err_o(err_o),
    .err_count_o(err_count_o));

  function automatic logic [W-1:0] step_x(input logic [W-1:0] x);
    logic [W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 7);
    return t ^ (t << 17);
  endfunction

  function automatic logic [W-1:0] ref_word(input int p);
    int s = p / SEG;
    logic [W-1:0] x = (s >= 2) ? SB : SA;
    for (int j = 0; j < p % SEG; j++) x = step_x(x);
    return (s % 2 == 1) ? ~x : x;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {63'd0, locked_o}, {63'd0, m_lock});
    chk(req, {63'd0, err_o}, {63'd0, m_err});
    chk(req, {{(W-CW){1'b0}}, err_count_o}, W'(m_cnt));
  endtask

  task automatic apply(input logic v, input logic [W-1:0] d, input string req);
    @(negedge clk);
    blk_valid_i = v;
    blk_data_i = d;
    m_err = 1'b0;
    if (v) begin
      if (!m_lock) begin
        if (d == SA) begin m_lock = 1'b1; m_pos = 1; m_miss = 0; end
      end else begin
        if (d != ref_word(m_pos)) begin
          m_err = 1'b1;
          if (m_cnt < CMAX) m_cnt++;
          m_miss++;
          if (m_miss == LOSS) begin m_lock = 1'b0; m_miss = 0; end
        end else m_miss = 0;
        m_pos = (m_pos + 1) % PERIOD;
      end
    end
    @(negedge clk);
    blk_valid_i = 1'b0;
    check_all(req);
  endtask

  task automatic do_restart(input logic v, input logic [W-1:0] d);
    @(negedge clk);
    restart_i = 1'b1;
    blk_valid_i = v;
    blk_data_i = d;
    @(negedge clk);
    restart_i = 1'b0;
    blk_valid_i = 1'b0;
    m_lock = 1'b0; m_cnt = 0; m_miss = 0; m_err = 1'b0;
    check_all("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    for (int i = 0; i < W; i++) apply(1'b1, SA ^ (64'd1 << i), "R2");
    apply(1'b1, ~SA, "R2");
    apply(1'b0, SA, "R6");
    apply(1'b1, SA, "R3");
    chk("R3", {63'd0, locked_o}, 64'd1);
    apply(1'b1, ref_word(1), "R5");
    chk("R5", {63'd0, err_o}, 64'd0);

    for (int k = 0; k < 3 * PERIOD; k++) begin
      apply(1'b1, ref_word(m_pos), "R4");
      if (k % 5 == 0) apply(1'b0, ~ref_word(m_pos), "R6");
    end

    apply(1'b1, ref_word(m_pos) ^ 64'd1, "R7");
    apply(1'b1, ~ref_word(m_pos), "R7");
    chk("R7", {{(W-CW){1'b0}}, err_count_o}, 64'd2);
    apply(1'b1, ref_word(m_pos), "R7");

    for (int k = 0; k < LOSS - 1; k++) apply(1'b1, ~ref_word(m_pos), "R8");
    apply(1'b1, ref_word(m_pos), "R8");
    chk("R8", {63'd0, locked_o}, 64'd1);
    for (int k = 0; k < LOSS; k++) apply(1'b1, ref_word(m_pos) ^ 64'hF0, "R8");
    chk("R8", {63'd0, locked_o}, 64'd0);
    apply(1'b1, ref_word(m_pos) ^ 64'hF0, "R2");
    apply(1'b1, SA, "R3");

    for (int k = 0; k < 40; k++) begin
      apply(1'b1, ~ref_word(m_pos), "R9");
      apply(1'b1, ref_word(m_pos), "R9");
    end
    chk("R9", {{(W-CW){1'b0}}, err_count_o}, W'(CMAX));

    do_restart(1'b0, '0);
    apply(1'b1, SA, "R3");
    apply(1'b1, ~ref_word(m_pos), "R7");
    do_restart(1'b1, SA);
    apply(1'b1, ref_word(1), "R2");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule